// File: doc/BRIEF.md
# Configurable Digital Port Pin Controller

This block controls one port of digital pins, eight by default. It holds three registers: a data latch, a per-bit output-mode register that selects push-pull or open-drain, and a per-bit input-mode register that selects digital or analog. A pin can also be handed to an on-chip peripheral through the pin-assignment crossbar. The block takes that ownership as a per-bit flag, together with the peripheral's output value and output enable. From all of this it produces three pad controls per pin: drive-low, drive-high and weak pull-up enable. It also produces a per-pin analog flag, which tells the crossbar to skip that pin when it assigns pins.

The bus side writes a whole register at once or a single bit of it. It reads in two ways. A plain read of the data register returns the level sensed on the pins. A read marked as the read phase of a read-modify-write returns the latch instead, so that a later write-back does not copy pin levels into the latch. Writes to pins that the crossbar owns change the latch, but they do not change what those pins drive.

Top module: `gpio_port`

## Requirements
- R1: After synchronous reset the data latch is all ones, the output-mode register is all zeros (open-drain), the input-mode register is all ones (digital), and `rd_data` is zero.
- R2: A read with `rd_sel`=0 and `rd_rmw`=0 returns `pin_in` in the next cycle. Any bit whose input-mode bit is 0 (analog) reads as 0.
- R3: A read with `rd_sel`=0 and `rd_rmw`=1 returns the data latch in the next cycle, whatever the pin levels are.
- R4: `wr_sel` selects the register: 0 is the latch, 1 is output mode, 2 is input mode, and 3 is nothing. With `wr_bit`=0 the write loads all bits from `wr_data`. With `wr_bit`=1 only bit `wr_idx` changes, and it takes `wr_data[wr_idx]`. Reads with `rd_sel` 1 and 2 return those registers, and `rd_sel`=3 returns 0. A read that falls in the same cycle as a write returns the value held before the write.
- R5: On a pin the port controls, when the output-mode bit is 1 (push-pull) and the pin is not forced to open-drain: a latch value of 0 asserts `drv_lo`, and a latch value of 1 asserts `drv_hi`.
- R6: In open-drain mode a latch value of 0 asserts `drv_lo`, and a latch value of 1 leaves both drivers off.
- R7: A pin with `force_od` set never asserts `drv_hi`, whatever its output-mode bit says.
- R8: On a pin with `xbar_own` set, `per_out` and `per_oe` take the place of the latch and the always-on enable. When `per_oe` is 0 both drivers are off, and writes to the latch do not change the pad controls.
- R9: `pull_en` is 1 only when `pull_dis` is 0, the pin is not asserting `drv_lo`, and the pin is digital.
- R10: `analog_skip` is 1 on exactly those bits whose input-mode bit is 0.
- R11: `rd_data` holds its value in any cycle without `rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Register selected for the write |
| wr_bit | input | 1 | 1 = single-bit write, 0 = whole-register write |
| wr_idx | input | 3 | Bit index for a single-bit write |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_rmw | input | 1 | Marks the read as the read phase of a read-modify-write |
| rd_sel | input | 2 | Register selected for the read |
| rd_data | output | 8 | Read data, registered |
| pin_in | input | 8 | Levels sensed on the pads |
| xbar_own | input | 8 | Pin is owned by a crossbar peripheral |
| per_out | input | 8 | Peripheral output value |
| per_oe | input | 8 | Peripheral output enable |
| force_od | input | 8 | Force open-drain on the pin |
| pull_dis | input | 1 | Global weak pull-up disable |
| drv_lo | output | 8 | Pad pull-down driver enable |
| drv_hi | output | 8 | Pad pull-up driver enable |
| pull_en | output | 8 | Weak pull-up enable |
| analog_skip | output | 8 | Pin is analog; the crossbar skips it |

## Verification
The hardest case to reach is a read-modify-write read that meets a latch that differs from the pins. That happens when a pin is crossbar-owned, analog, or held low externally while the latch holds 1. The stimulus writes the latch, then changes `pin_in` and ownership, and then issues plain and read-modify-write reads back to back so that the two answers diverge. Single-bit writes to owned pins are mixed in, and the bench checks that the pads do not move. A long random phase afterwards varies ownership, forced open-drain, and both mode registers together.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    typedef enum logic [1:0] {
        SEL_DATA  = 2'd0,
        SEL_OMODE = 2'd1,
        SEL_IMODE = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic drv_lo;
        logic drv_hi;
        logic pull_en;
    } pad_ctl_t;

    // One pin: choose the source of the output, apply the output mode, then the pull-up rule.
    function automatic pad_ctl_t pad_eval(
        input logic own,
        input logic per_val,
        input logic per_en,
        input logic latch,
        input logic pushpull,
        input logic force_od,
        input logic digital,
        input logic pull_dis
    );
        pad_ctl_t p;
        logic     val;
        logic     act;
        val       = own ? per_val : latch;
        act       = own ? per_en  : 1'b1;
        p.drv_lo  = act & ~val;
        p.drv_hi  = act & val & pushpull & ~force_od;
        p.pull_en = ~pull_dis & ~p.drv_lo & digital;
        return p;
    endfunction

endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_port_pkg::*;
#(
    parameter int W  = 8,
    parameter int IW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  reg_sel_e      wr_sel,
    input  logic          wr_bit,
    input  logic [IW-1:0] wr_idx,
    input  logic [W-1:0]  wr_data,
    output logic [W-1:0]  latch_q,
    output logic [W-1:0]  omode_q,
    output logic [W-1:0]  imode_q
);

    logic [W-1:0] mask;

    always_comb begin
        if (wr_bit) mask = W'(1) << wr_idx;
        else        mask = '1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q <= '1;
            omode_q <= '0;
            imode_q <= '1;
        end else if (wr_en) begin
            unique case (wr_sel)
                SEL_DATA:  latch_q <= (latch_q & ~mask) | (wr_data & mask);
                SEL_OMODE: omode_q <= (omode_q & ~mask) | (wr_data & mask);
                SEL_IMODE: imode_q <= (imode_q & ~mask) | (wr_data & mask);
                default:   ;
            endcase
        end
    end

endmodule

// File: rtl/gpio_pad_ctl.sv
module gpio_pad_ctl
    import gpio_port_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] latch_q,
    input  logic [W-1:0] omode_q,
    input  logic [W-1:0] imode_q,
    input  logic [W-1:0] xbar_own,
    input  logic [W-1:0] per_out,
    input  logic [W-1:0] per_oe,
    input  logic [W-1:0] force_od,
    input  logic         pull_dis,
    output logic [W-1:0] drv_lo,
    output logic [W-1:0] drv_hi,
    output logic [W-1:0] pull_en
);

    for (genvar i = 0; i < W; i++) begin : g_pin
        pad_ctl_t ctl;
        always_comb begin
            ctl = pad_eval(xbar_own[i], per_out[i], per_oe[i], latch_q[i],
                           omode_q[i], force_od[i], imode_q[i], pull_dis);
        end
        assign drv_lo[i]  = ctl.drv_lo;
        assign drv_hi[i]  = ctl.drv_hi;
        assign pull_en[i] = ctl.pull_en;
    end

endmodule

// File: rtl/gpio_rd_mux.sv
module gpio_rd_mux
    import gpio_port_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         rd_en,
    input  logic         rd_rmw,
    input  reg_sel_e     rd_sel,
    input  logic [W-1:0] pin_in,
    input  logic [W-1:0] latch_q,
    input  logic [W-1:0] omode_q,
    input  logic [W-1:0] imode_q,
    output logic [W-1:0] rd_data
);

    logic [W-1:0] pin_view;
    logic [W-1:0] rd_next;

    // Analog pins have no digital input path.
    assign pin_view = pin_in & imode_q;

    always_comb begin
        unique case (rd_sel)
            SEL_DATA:  rd_next = rd_rmw ? latch_q : pin_view;
            SEL_OMODE: rd_next = omode_q;
            SEL_IMODE: rd_next = imode_q;
            default:   rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)        rd_data <= '0;
        else if (rd_en) rd_data <= rd_next;
    end

endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_port_pkg::*;
#(
    parameter int W = 8,
    localparam int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [1:0]    wr_sel,
    input  logic          wr_bit,
    input  logic [IW-1:0] wr_idx,
    input  logic [W-1:0]  wr_data,
    input  logic          rd_en,
    input  logic          rd_rmw,
    input  logic [1:0]    rd_sel,
    output logic [W-1:0]  rd_data,
    input  logic [W-1:0]  pin_in,
    input  logic [W-1:0]  xbar_own,
    input  logic [W-1:0]  per_out,
    input  logic [W-1:0]  per_oe,
    input  logic [W-1:0]  force_od,
    input  logic          pull_dis,
    output logic [W-1:0]  drv_lo,
    output logic [W-1:0]  drv_hi,
    output logic [W-1:0]  pull_en,
    output logic [W-1:0]  analog_skip
);

    logic [W-1:0] latch_q;
    logic [W-1:0] omode_q;
    logic [W-1:0] imode_q;

    gpio_regs #(.W(W), .IW(IW)) i_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (reg_sel_e'(wr_sel)),
        .wr_bit  (wr_bit),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .latch_q (latch_q),
        .omode_q (omode_q),
        .imode_q (imode_q)
    );

    gpio_pad_ctl #(.W(W)) i_pad (
        .latch_q  (latch_q),
        .omode_q  (omode_q),
        .imode_q  (imode_q),
        .xbar_own (xbar_own),
        .per_out  (per_out),
        .per_oe   (per_oe),
        .force_od (force_od),
        .pull_dis (pull_dis),
        .drv_lo   (drv_lo),
        .drv_hi   (drv_hi),
        .pull_en  (pull_en)
    );

    gpio_rd_mux #(.W(W)) i_rd (
        .clk     (clk),
        .rst     (rst),
        .rd_en   (rd_en),
        .rd_rmw  (rd_rmw),
        .rd_sel  (reg_sel_e'(rd_sel)),
        .pin_in  (pin_in),
        .latch_q (latch_q),
        .omode_q (omode_q),
        .imode_q (imode_q),
        .rd_data (rd_data)
    );

    assign analog_skip = ~imode_q;

endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         rd_en,
    input logic         rd_rmw,
    input logic [1:0]   rd_sel,
    input logic [W-1:0] rd_data,
    input logic [W-1:0] latch_q,
    input logic [W-1:0] force_od,
    input logic [W-1:0] xbar_own,
    input logic [W-1:0] per_oe,
    input logic         pull_dis,
    input logic [W-1:0] drv_lo,
    input logic [W-1:0] drv_hi,
    input logic [W-1:0] pull_en,
    input logic [W-1:0] analog_skip
);

    a_r5_no_both_drivers: assert property (@(posedge clk) disable iff (rst)
        (drv_lo & drv_hi) == '0);

    a_r7_forced_od: assert property (@(posedge clk) disable iff (rst)
        (force_od & drv_hi) == '0);

    a_r8_owned_idle: assert property (@(posedge clk) disable iff (rst)
        (xbar_own & ~per_oe & (drv_lo | drv_hi)) == '0);

    a_r9_pull_released: assert property (@(posedge clk) disable iff (rst)
        (drv_lo & pull_en) == '0);

    a_r9_global_off: assert property (@(posedge clk) disable iff (rst)
        pull_dis |-> pull_en == '0);

    a_r10_analog_no_pull: assert property (@(posedge clk) disable iff (rst)
        (analog_skip & pull_en) == '0);

    a_r3_rmw_latch: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_rmw && rd_sel == 2'd0) |=> rd_data == $past(latch_q));

    a_r11_hold: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data));

endmodule

bind gpio_port gpio_port_chk #(.W(W)) i_chk (.*);

// File: tb/test_gpio_port.sv
`timescale 1ns/1ps
module test_gpio_port;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 0, wr_bit = 0, rd_en = 0, rd_rmw = 0, pull_dis = 0;
    logic [1:0] wr_sel = 0, rd_sel = 0;
    logic [2:0] wr_idx = 0;
    logic [7:0] wr_data = 0, pin_in = 0, xbar_own = 0, per_out = 0, per_oe = 0, force_od = 0;
    logic [7:0] rd_data, drv_lo, drv_hi, pull_en, analog_skip;

    int vectors = 0;
    int misses  = 0;
    bit done    = 0;

    // reference state
    logic [7:0] m_latch, m_om, m_im, m_rd;
    string      m_rdtag;

    always #2 clk = ~clk;

    gpio_port i_gpio_port (.*);

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        vectors++;
        if (got !== exp) begin
            misses++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    task automatic compare();
        for (int i = 0; i < 8; i++) begin
            logic act, v, elo, ehi, epu;
            string tag;
            if (xbar_own[i]) begin act = per_oe[i]; v = per_out[i]; tag = "R8 pad"; end
            else begin
                act = 1'b1; v = m_latch[i];
                if (force_od[i] && m_om[i]) tag = "R7 pad";
                else if (m_om[i])           tag = "R5 pad";
                else                        tag = "R6 pad";
            end
            elo = act && !v;
            ehi = act && v && m_om[i] && !force_od[i];
            epu = !pull_dis && !elo && m_im[i];
            chk(tag, {7'd0, drv_lo[i]}, {7'd0, elo});
            chk(tag, {7'd0, drv_hi[i]}, {7'd0, ehi});
            chk("R9 pull", {7'd0, pull_en[i]}, {7'd0, epu});
        end
        chk("R10 skip", analog_skip, ~m_im);
        chk(m_rdtag, rd_data, m_rd);
    endtask

    // Apply one cycle of bus stimulus, advance the model, then compare after the edge.
    task automatic cyc(input logic we, input logic [1:0] ws, input logic wb, input logic [2:0] wi,
                       input logic [7:0] wd, input logic re, input logic rmw, input logic [1:0] rs);
        logic [7:0] mask;
        wr_en = we; wr_sel = ws; wr_bit = wb; wr_idx = wi; wr_data = wd;
        rd_en = re; rd_rmw = rmw; rd_sel = rs;
        if (re) begin
            case (rs)
                2'd0: begin
                    m_rd    = rmw ? m_latch : (pin_in & m_im);
                    m_rdtag = rmw ? "R3 rmw read" : "R2 pin read";
                end
                2'd1: begin m_rd = m_om; m_rdtag = "R4 mode read"; end
                2'd2: begin m_rd = m_im; m_rdtag = "R4 mode read"; end
                default: begin m_rd = 8'h00; m_rdtag = "R4 empty read"; end
            endcase
        end else begin
            m_rdtag = "R11 hold";
        end
        if (we) begin
            mask = wb ? (8'h01 << wi) : 8'hff;
            case (ws)
                2'd0: m_latch = (m_latch & ~mask) | (wd & mask);
                2'd1: m_om    = (m_om & ~mask) | (wd & mask);
                2'd2: m_im    = (m_im & ~mask) | (wd & mask);
                default: ;
            endcase
        end
        @(negedge clk);
        compare();
    endtask

    task automatic idle();
        cyc(0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            misses++;
            vectors++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        m_latch = 8'hff; m_om = 8'h00; m_im = 8'hff; m_rd = 8'h00; m_rdtag = "R1 reset";
        repeat (3) @(negedge clk);
        rst = 0;
        compare();                                  // R1 reset state on pads and rd_data
        cyc(0, 0, 0, 0, 0, 1, 1, 0); chk("R1 latch", rd_data, 8'hff);
        cyc(0, 0, 0, 0, 0, 1, 0, 1); chk("R1 omode", rd_data, 8'h00);
        cyc(0, 0, 0, 0, 0, 1, 0, 2); chk("R1 imode", rd_data, 8'hff);

        // R5 push-pull, R4 byte and bit writes
        cyc(1, 1, 0, 0, 8'hff, 0, 0, 0);
        cyc(1, 0, 0, 0, 8'ha5, 0, 0, 0);
        cyc(1, 0, 1, 3'd0, 8'h00, 1, 1, 0);         // bit 0 cleared, read returns the old latch
        cyc(1, 0, 1, 3'd6, 8'h40, 1, 1, 0);
        cyc(1, 3, 0, 0, 8'h00, 1, 0, 3);            // R4 select 3: write ignored, read zero
        // R6 open-drain
        cyc(1, 1, 0, 0, 8'h00, 1, 0, 1);
        cyc(1, 1, 1, 3'd2, 8'h04, 1, 0, 1);
        // R7 forced open-drain
        force_od = 8'h0f;
        cyc(1, 1, 0, 0, 8'hff, 0, 0, 0);
        cyc(1, 0, 0, 0, 8'hff, 0, 0, 0);
        force_od = 8'h00;
        // R8 crossbar ownership: latch writes leave owned pins alone
        xbar_own = 8'hf0; per_out = 8'h30; per_oe = 8'h70;
        cyc(1, 0, 0, 0, 8'h00, 0, 0, 0);
        cyc(1, 0, 1, 3'd5, 8'hff, 0, 0, 0);
        // R3 against R2: latch differs from pins
        pin_in = 8'h0f;
        cyc(0, 0, 0, 0, 0, 1, 1, 0);
        cyc(0, 0, 0, 0, 0, 1, 0, 0);
        idle();                                      // R11 hold
        xbar_own = 0; per_out = 0; per_oe = 0;
        // R9 global pull-up disable
        pull_dis = 1; idle(); pull_dis = 0;
        // R10 analog pins read as zero
        cyc(1, 2, 0, 0, 8'he3, 0, 0, 0);
        pin_in = 8'hff;
        cyc(1, 0, 0, 0, 8'hff, 1, 0, 0);
        cyc(0, 0, 0, 0, 0, 1, 0, 0);
        cyc(0, 0, 0, 0, 0, 1, 1, 0);

        for (int n = 0; n < 4000; n++) begin
            pin_in   = 8'($urandom);
            xbar_own = 8'($urandom) & 8'($urandom);
            per_out  = 8'($urandom);
            per_oe   = 8'($urandom);
            force_od = 8'($urandom) & 8'($urandom);
            pull_dis = ($urandom % 8) == 0;
            cyc(1'($urandom), 2'($urandom), 1'($urandom), 3'($urandom), 8'($urandom),
                1'($urandom), 1'($urandom), 2'($urandom));
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule